// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the register side of a single transmit or receive DMA channel inside a serial engine. Software programs a 64-bit buffer address as two 32-bit words, an optional end-of-transfer attribute, and finally a byte count. A nonzero byte count arms the channel. The block then issues a one-cycle start request, together with the address, the length and the attribute, to an abstract data mover. The mover reports completion or a bus error through a few event inputs. These events are collected into a write-1-to-clear status register. The channel also reports the number of bytes that were actually moved.

Interrupt enables are never changed with read-modify-write. Software writes ones to a set word to enable sources and ones to a clear word to disable them. The interrupt output is raised while any pending status bit is also enabled. A parameter chooses the transmit variant, which keeps the end-of-transfer attribute bit, or the receive variant, in which that bit does not exist and reads as zero.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous active-low reset, every readable word reads zero, `busy` is 0 and `irq` is 0.
- R2: Word 0 holds the low address half and word 1 holds the high half. Both read back as written, and `mv_addr` equals {word 1, word 0}.
- R3: Interrupt-enable bits are: bit 0 = done, bit 1 = end of transfer, bit 2 = bus error. Writing ones to word 5 sets those enables and writing ones to word 6 clears them. Word 4 reads the enables, and bits above 2 read zero.
- R4: A write of a nonzero value to word 3 (length) while idle sets `busy` at the write edge. It also raises `mv_start` for exactly that one following cycle, with `mv_len` equal to the value. A zero length is stored but does not start a transfer.
- R5: While `busy` is 1, writes to words 0, 1, 2 and 3 are ignored.
- R6: A done event while busy sets status bit 0. It sets status bit 1 only when attribute bit 0 was set (transmit variant). It clears `busy`.
- R7: A bus-error event while busy sets status bit 2 and clears `busy`. Error takes precedence over a simultaneous done event, so bit 0 is not set.
- R8: When either event ends a transfer, word 8 captures `mv_count`. Events that arrive while idle change neither the status nor word 8.
- R9: Writing ones to word 7 clears the matching status bits. If an event sets a bit in the same cycle, the set wins.
- R10: `irq` is high exactly when some status bit and its enable bit are both 1.
- R11: Word 2 bit 0 is the end-of-transfer attribute and drives `mv_eot` on the transmit variant. On the receive variant, word 2 always reads zero and `mv_eot` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write word index |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | 4 | Read word index |
| reg_rdata | output | DATA_W | Read data (combinational) |
| mv_start | output | 1 | One-cycle start request to the mover |
| mv_addr | output | 2*DATA_W | Buffer address |
| mv_len | output | LEN_W | Programmed byte count |
| mv_eot | output | 1 | End-of-transfer attribute |
| mv_done | input | 1 | Mover completed the transfer |
| mv_err | input | 1 | Mover saw a bus error |
| mv_count | input | LEN_W | Bytes moved, valid with an event |
| busy | output | 1 | Transfer in flight |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a status clear that lands in the same clock cycle as a mover event that sets a bit. It needs a register write and a mover pulse driven together on one edge. The bench forces this directly by driving both in the same cycle. It does the same for a done event that coincides with an error event. Random transfers, with random enables, attributes and error outcomes, then cover the ordinary paths, including partial byte counts after an error.

// File: rtl/dmach_pkg.sv
// Shared word indices and status bit positions for the DMA channel registers.
package dmach_pkg;
    typedef enum logic [3:0] {
        SEL_PTR_LO  = 4'd0,
        SEL_PTR_HI  = 4'd1,
        SEL_ATTR    = 4'd2,
        SEL_LEN     = 4'd3,
        SEL_IEN     = 4'd4,
        SEL_IEN_SET = 4'd5,
        SEL_IEN_CLR = 4'd6,
        SEL_STAT    = 4'd7,
        SEL_MOVED   = 4'd8
    } sel_e;

    localparam int ST_DONE = 0;
    localparam int ST_EOT  = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_W    = 3;
endpackage

// File: rtl/dmach_setup.sv
// Setup registers: address halves, attribute and length.
// Assumes: writes are blocked while a transfer is in flight; the receive
// variant (IS_TX = 0) has no attribute storage.
module dmach_setup #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 32,
    parameter bit IS_TX  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [3:0]        waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [DATA_W-1:0] ptr_lo,
    output logic [DATA_W-1:0] ptr_hi,
    output logic              attr_eot,
    output logic [LEN_W-1:0]  len,
    output logic              go
);
    import dmach_pkg::*;

    logic wr_ok;
    assign wr_ok = wr && !busy;

    // Arm a transfer on a nonzero length write while idle.
    assign go = wr_ok && (waddr == SEL_LEN) && (wdata[LEN_W-1:0] != '0);

    // Pointer and length storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_lo <= '0;
            ptr_hi <= '0;
            len    <= '0;
        end else if (wr_ok) begin
            if (waddr == SEL_PTR_LO) ptr_lo <= wdata;
            if (waddr == SEL_PTR_HI) ptr_hi <= wdata;
            if (waddr == SEL_LEN)    len    <= wdata[LEN_W-1:0];
        end
    end

    generate
        if (IS_TX) begin : g_tx_attr
            logic eot_q;
            // End-of-transfer attribute bit, transmit variant only.
            always_ff @(posedge clk) begin
                if (!rst_n)                             eot_q <= 1'b0;
                else if (wr_ok && waddr == SEL_ATTR)    eot_q <= wdata[0];
            end
            assign attr_eot = eot_q;
        end else begin : g_rx_attr
            assign attr_eot = 1'b0;
        end
    endgenerate

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr && waddr == SEL_PTR_LO |=> ptr_lo == $past(ptr_lo)); // R5
endmodule

// File: rtl/dmach_seq.sv
// Transfer sequencing: busy flag, start pulse, end detection, byte capture.
// Assumes: mover events are meaningful only while busy.
module dmach_seq #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             mv_done,
    input  logic             mv_err,
    input  logic [LEN_W-1:0] mv_count,
    output logic             busy,
    output logic             start,
    output logic             fin_done,
    output logic             fin_err,
    output logic [LEN_W-1:0] moved
);
    // Error outranks done when both arrive together.
    assign fin_err  = busy && mv_err;
    assign fin_done = busy && mv_done && !mv_err;

    // Busy flag and one-cycle start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= go;
            if (go)                        busy <= 1'b1;
            else if (fin_done || fin_err)  busy <= 1'b0;
        end
    end

    // Capture bytes moved when a transfer ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                       moved <= '0;
        else if (fin_done || fin_err)     moved <= mv_count;
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R4
    AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (mv_done || mv_err) |=> !busy); // R6
endmodule

// File: rtl/dmach_intr.sv
// Interrupt enables (set/clear aliases), sticky status with write-1-to-clear,
// and the combined interrupt request. Assumes event pulses are pre-qualified.
module dmach_intr (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [3:0]                waddr,
    input  logic [dmach_pkg::ST_W-1:0] wbits,
    input  logic                      ev_done,
    input  logic                      ev_eot,
    input  logic                      ev_err,
    output logic [dmach_pkg::ST_W-1:0] ien,
    output logic [dmach_pkg::ST_W-1:0] stat,
    output logic                      irq
);
    import dmach_pkg::*;

    logic [ST_W-1:0] ev_set;
    logic [ST_W-1:0] w1c;

    // Gather event set bits in status bit order.
    always_comb begin
        ev_set          = '0;
        ev_set[ST_DONE] = ev_done;
        ev_set[ST_EOT]  = ev_eot;
        ev_set[ST_ERR]  = ev_err;
    end

    assign w1c = (wr && waddr == SEL_STAT) ? wbits : '0;

    // Enable register updated only through set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ien <= '0;
        else if (wr && waddr == SEL_IEN_SET)    ien <= ien | wbits;
        else if (wr && waddr == SEL_IEN_CLR)    ien <= ien & ~wbits;
    end

    // Sticky status: clear by writing ones, events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~w1c) | ev_set;
    end

    assign irq = |(stat & ien);

    AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> stat[ST_DONE]); // R9
    AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> stat[ST_ERR]); // R7
endmodule

// File: rtl/dma_chan_regs.sv
// Top: register front end of one DMA channel. Ties setup, sequencing and
// interrupt logic together and provides the combinational read mux.
// Assumes a single write port, so set and clear aliases never coincide.
module dma_chan_regs #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 32,
    parameter bit IS_TX  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [3:0]          reg_waddr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [3:0]          reg_raddr,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                mv_start,
    output logic [2*DATA_W-1:0] mv_addr,
    output logic [LEN_W-1:0]    mv_len,
    output logic                mv_eot,
    input  logic                mv_done,
    input  logic                mv_err,
    input  logic [LEN_W-1:0]    mv_count,
    output logic                busy,
    output logic                irq
);
    import dmach_pkg::*;

    logic [DATA_W-1:0] ptr_lo, ptr_hi;
    logic              attr_eot, go, fin_done, fin_err;
    logic [LEN_W-1:0]  len, moved;
    logic [ST_W-1:0]   ien, stat;

    dmach_setup #(.DATA_W(DATA_W), .LEN_W(LEN_W), .IS_TX(IS_TX)) u_setup (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr),
        .wdata(reg_wdata), .busy(busy), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
        .attr_eot(attr_eot), .len(len), .go(go));

    dmach_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .mv_done(mv_done), .mv_err(mv_err),
        .mv_count(mv_count), .busy(busy), .start(mv_start),
        .fin_done(fin_done), .fin_err(fin_err), .moved(moved));

    dmach_intr u_intr (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr),
        .wbits(reg_wdata[ST_W-1:0]), .ev_done(fin_done),
        .ev_eot(fin_done && attr_eot), .ev_err(fin_err),
        .ien(ien), .stat(stat), .irq(irq));

    assign mv_addr = {ptr_hi, ptr_lo};
    assign mv_len  = len;
    assign mv_eot  = attr_eot;

    // Read mux; unmapped words read zero.
    always_comb begin
        case (reg_raddr)
            SEL_PTR_LO: reg_rdata = ptr_lo;
            SEL_PTR_HI: reg_rdata = ptr_hi;
            SEL_ATTR:   reg_rdata = DATA_W'(attr_eot);
            SEL_LEN:    reg_rdata = DATA_W'(len);
            SEL_IEN:    reg_rdata = DATA_W'(ien);
            SEL_STAT:   reg_rdata = DATA_W'(stat);
            SEL_MOVED:  reg_rdata = DATA_W'(moved);
            default:    reg_rdata = '0;
        endcase
    end

    AST_START_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> mv_len != '0); // R4
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        t_wr = 0, r_wr = 0;
    logic [3:0]  t_waddr = 0, r_waddr = 0, t_raddr = 0, r_raddr = 0;
    logic [31:0] t_wdata = 0, r_wdata = 0, t_rdata, r_rdata;
    logic        t_start, r_start, t_eot, r_eot, t_busy, r_busy, t_irq, r_irq;
    logic [63:0] t_addr, r_addr;
    logic [31:0] t_len, r_len;
    logic        t_done = 0, t_err = 0, r_done = 0, r_err = 0;
    logic [31:0] t_cnt = 0, r_cnt = 0;

    int n_chk = 0, n_err = 0, start_cnt = 0;

    dma_chan_regs u_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(t_wr), .reg_waddr(t_waddr),
        .reg_wdata(t_wdata), .reg_raddr(t_raddr), .reg_rdata(t_rdata),
        .mv_start(t_start), .mv_addr(t_addr), .mv_len(t_len), .mv_eot(t_eot),
        .mv_done(t_done), .mv_err(t_err), .mv_count(t_cnt),
        .busy(t_busy), .irq(t_irq));

    dma_chan_regs #(.IS_TX(1'b0)) u_dma_chan_regs_rx (
        .clk(clk), .rst_n(rst_n), .reg_wr(r_wr), .reg_waddr(r_waddr),
        .reg_wdata(r_wdata), .reg_raddr(r_raddr), .reg_rdata(r_rdata),
        .mv_start(r_start), .mv_addr(r_addr), .mv_len(r_len), .mv_eot(r_eot),
        .mv_done(r_done), .mv_err(r_err), .mv_count(r_cnt),
        .busy(r_busy), .irq(r_irq));

    always @(posedge clk) if (t_start) start_cnt++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit rx, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (rx) begin r_wr = 1; r_waddr = a; r_wdata = d; end
        else    begin t_wr = 1; t_waddr = a; t_wdata = d; end
        @(posedge clk); #1;
        r_wr = 0; t_wr = 0;
    endtask

    task automatic rd(input bit rx, input logic [3:0] a, output logic [31:0] d);
        if (rx) begin r_raddr = a; #0.5; d = r_rdata; end
        else    begin t_raddr = a; #0.5; d = t_rdata; end
    endtask

    task automatic ev(input bit rx, input bit dn, input bit er, input logic [31:0] c);
        @(negedge clk);
        if (rx) begin r_done = dn; r_err = er; r_cnt = c; end
        else    begin t_done = dn; t_err = er; t_cnt = c; end
        @(posedge clk); #1;
        r_done = 0; r_err = 0; t_done = 0; t_err = 0;
    endtask

    function automatic logic exp_irq(input logic [2:0] st, input logic [2:0] ie);
        return |(st & ie);
    endfunction

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] d, lo, hi, ln, cnt, w;
        logic [2:0]  e_stat, e_ien;
        logic        at, is_err;
        int          sc;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        for (int a = 0; a < 9; a++) begin
            rd(0, 4'(a), d); chk("R1 word", d, 0);
        end
        chk("R1 busy", t_busy, 0); chk("R1 irq", t_irq, 0);

        // R2 pointer halves
        wr(0, 0, 32'h89ab_cdef); wr(0, 1, 32'h0123_4567);
        rd(0, 0, d); chk("R2 lo", d, 32'h89ab_cdef);
        rd(0, 1, d); chk("R2 hi", d, 32'h0123_4567);
        chk("R2 mv_addr", t_addr, 64'h0123_4567_89ab_cdef);

        // R3 enable set/clear aliases
        wr(0, 5, 5); rd(0, 4, d); chk("R3 set", d, 5);
        wr(0, 5, 2); rd(0, 4, d); chk("R3 set2", d, 7);
        wr(0, 6, 1); rd(0, 4, d); chk("R3 clr", d, 6);
        wr(0, 5, 32'hffff_ffff); rd(0, 4, d); chk("R3 upper zero", d, 7);
        wr(0, 6, 7); e_ien = 0;

        // R4 zero length does not start
        sc = start_cnt;
        wr(0, 3, 0); chk("R4 zero busy", t_busy, 0);
        @(posedge clk); #1 chk("R4 zero no start", start_cnt, sc);

        // R8 idle events ignored
        ev(0, 1, 1, 77);
        rd(0, 7, d); chk("R8 idle stat", d, 0);
        rd(0, 8, d); chk("R8 idle moved", d, 0);

        // Random transfers
        for (int i = 0; i < 40; i++) begin
            lo = $urandom; hi = $urandom; at = 1'($urandom % 2);
            ln = 1 + $urandom % 500; e_ien = 3'($urandom % 8);
            wr(0, 0, lo); wr(0, 1, hi); wr(0, 2, {31'b0, at});
            wr(0, 6, 7); wr(0, 5, {29'b0, e_ien}); wr(0, 7, 32'hffff_ffff);
            sc = start_cnt;
            wr(0, 3, ln);
            chk("R4 busy", t_busy, 1); chk("R4 start", t_start, 1);
            chk("R4 mv_len", t_len, ln); chk("R2 mv_addr", t_addr, {hi, lo});
            chk("R11 mv_eot", t_eot, at);
            @(posedge clk); #1;
            chk("R4 start one cycle", t_start, 0); chk("R4 start count", start_cnt, sc + 1);
            // R5 writes while busy ignored
            wr(0, 0, ~lo); rd(0, 0, d); chk("R5 ptr lo held", d, lo);
            wr(0, 3, ln + 1); chk("R5 len held", t_len, ln);
            chk("R5 no restart", t_start, 0);
            repeat ($urandom % 4) @(posedge clk);
            is_err = ($urandom % 4) == 0;
            cnt = is_err ? $urandom % ln : ln;
            ev(0, !is_err, is_err, cnt);
            e_stat = is_err ? 3'b100 : {1'b0, at, 1'b1};
            rd(0, 7, d); chk(is_err ? "R7 stat" : "R6 stat", d, {29'b0, e_stat});
            chk("R6 busy clear", t_busy, 0);
            rd(0, 8, d); chk("R8 moved", d, cnt);
            chk("R10 irq", t_irq, exp_irq(e_stat, e_ien));
            w = $urandom % 8; wr(0, 7, w); e_stat = e_stat & ~w[2:0];
            rd(0, 7, d); chk("R9 w1c", d, {29'b0, e_stat});
            chk("R10 irq after clear", t_irq, exp_irq(e_stat, e_ien));
        end

        // R9 clear and done in the same cycle: set wins
        wr(0, 7, 32'hffff_ffff); wr(0, 5, 7); wr(0, 2, 1); wr(0, 3, 5);
        @(negedge clk);
        t_wr = 1; t_waddr = 7; t_wdata = 32'hffff_ffff; t_done = 1; t_cnt = 5;
        @(posedge clk); #1 t_wr = 0; t_done = 0;
        rd(0, 7, d); chk("R9 set wins", d, 3);
        chk("R10 irq set", t_irq, 1);

        // R7 error outranks simultaneous done
        wr(0, 7, 32'hffff_ffff); wr(0, 3, 9);
        ev(0, 1, 1, 3);
        rd(0, 7, d); chk("R7 err wins", d, 4);
        rd(0, 8, d); chk("R7 partial count", d, 3);

        // R11 receive variant
        wr(1, 2, 1); rd(1, 2, d); chk("R11 rx attr", d, 0);
        wr(1, 3, 4); chk("R11 rx eot", r_eot, 0); chk("R4 rx busy", r_busy, 1);
        ev(1, 1, 0, 4);
        rd(1, 7, d); chk("R11 rx stat", d, 1);

        summary();
    end
endmodule